// File: doc/BRIEF.md
# Programmable-Modulus Third-Order Fractional Interpolator

This block produces the per-cycle divide value for a fractional-N feedback divider. It advances once for each phase-detector reference cycle. Over time the average of the values it emits equals an integer part N plus a fraction FRAC/MOD. The modulus MOD can be set to any integer from 2 to 4095, so the channel step is the reference rate divided by MOD.

Three first-order accumulators are chained. Each one wraps at MOD, not at a power of two. The carries from the three stages are combined with first- and second-difference terms. This pushes the quantization error up in frequency with a third-order high-pass shape. The result is a signed offset from -3 to +4, which is added to N.

An optional pseudo-random source can add one extra LSB to the first accumulator. This breaks up the short repeat cycles, at the cost of a broader noise floor. A load strobe takes a whole new setting and restarts the modulator from a known state. The divide values leave on a valid/ready stream. The modulator steps only when a value is accepted, so a stalled consumer sees the same value held and nothing is skipped.

Top module: `sdm_frac_interp`

## Requirements
- R1: While reset is asserted and after it is released, `div_valid` and `cfg_err` are 0 until the first load.
- R2: A load is accepted when 2 <= `cfg_mod`, `cfg_frac` < `cfg_mod`, and (`cfg_dither` = 0 or `cfg_mod` >= 50). After an accepted load, from the next cycle `div_valid` = 1 and `cfg_err` = 0. With dither off, the first value presented is exactly `cfg_int`.
- R3: A load that breaks any rule of R2 sets `cfg_err` = 1 and `div_valid` = 0 from the next cycle. The illegal cases are MOD below 2, FRAC not below MOD, and dither on with MOD below 50.
- R4: Every value presented while `div_valid` = 1 lies between N-3 and N+4 inclusive.
- R5: With dither off, the offsets (value minus N) summed over any one repeat length L add up to exactly L*FRAC/MOD.
- R6: With dither off, from the third value after a load the sequence repeats every L values. L is MOD when MOD is divisible by neither 2 nor 3, 2*MOD when MOD is even and not a multiple of 3, 3*MOD when MOD is odd and a multiple of 3, and 6*MOD when MOD is a multiple of 6.
- R7: The modulator advances only on a cycle with `div_valid` and `div_ready` both 1 and no load. While `div_ready` = 0 the presented value stays unchanged. After the stall the sequence resumes with no value skipped or repeated.
- R8: Each stage i adds its input to an accumulator that wraps modulo MOD and emits a carry ci. Stage 1 takes FRAC plus the dither bit, and later stages take the previous stage's new residue. The offset is c1 + (c2 - c2 one step earlier) + (c3 - 2*c3 one step earlier + c3 two steps earlier). For MOD=4095 and FRAC=4094, the first four values are N, N+3, N, N+1.
- R9: The dither bit comes from a 21-bit maximal-length shift register with feedback polynomial x^21 + x^19 + 1, whose state is never zero. Every load reseeds it, so a dithered run after a load is reproducible. With dither on, the sequence differs from the dither-off sequence for the same setting.
- R10: A load clears all accumulators and delay registers and restarts the sequence from its first value, even in the middle of a stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Strobe: take the setting on the cfg inputs and restart |
| cfg_int | input | INT_W (10) | Integer divide part N, expected in 3 .. 2^INT_W-5 |
| cfg_frac | input | MOD_W (12) | Fractional numerator FRAC |
| cfg_mod | input | MOD_W (12) | Modulus MOD |
| cfg_dither | input | 1 | 1 enables the pseudo-random LSB dither |
| cfg_err | output | 1 | Last load was rejected |
| div_valid | output | 1 | A divide value is being presented |
| div_ready | input | 1 | Consumer accepts the presented value |
| div_value | output | INT_W+1 (11) | Divide value N + offset for this reference cycle |

## Verification
A load is sampled at one clock edge. Its effects (`div_valid`, `cfg_err` and the first divide value) appear right after that edge, because the settings are registered and the value is built combinationally from the cleared state. Each later value appears just after the edge on which the previous one was accepted. The bench drives inputs and samples outputs on the falling edge: first it records the presented value, then it lets the next rising edge take it. The n-th recorded value after a load is therefore exactly the n-th term of the sequence. During a stall the bench samples on several falling edges in a row and expects the same value each time.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  // signed offset added to the integer part, range -3 .. +4
  typedef logic signed [3:0] off_t;
  localparam int STAGES         = 3;
  localparam int PRBS_LEN       = 21;
  localparam int PRBS_TAP       = 19;
  localparam int DITHER_MIN_MOD = 50;
  localparam int MIN_MOD        = 2;
endpackage

// File: rtl/sdm_mod_accum.sv
// One first-order stage: accumulator wrapping modulo a programmable modulus.
module sdm_mod_accum #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] modulus,
  input  logic [W:0]   addend,
  output logic         carry,
  output logic [W-1:0] resid
);
  logic [W-1:0] acc_q;
  logic [W+1:0] sum;
  logic [W+1:0] sum_wrapped;

  always_comb begin
    sum         = {2'b00, acc_q} + {1'b0, addend};
    sum_wrapped = sum - {2'b00, modulus};
    carry       = (sum >= {2'b00, modulus});
    resid       = carry ? sum_wrapped[W-1:0] : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else if (adv) acc_q <= resid;
  end
endmodule

// File: rtl/sdm_prbs.sv
// Maximal-length Fibonacci shift register used as the dither source.
module sdm_prbs #(
  parameter int LEN = sdm_pkg::PRBS_LEN,
  parameter int TAP = sdm_pkg::PRBS_TAP
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reseed,
  input  logic adv,
  output logic bit_o
);
  localparam logic [LEN-1:0] SEED = {{(LEN-1){1'b0}}, 1'b1};
  logic [LEN-1:0] state_q;
  logic           fb;

  assign fb    = state_q[LEN-1] ^ state_q[TAP-1];
  assign bit_o = state_q[LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= SEED;
    else if (reseed) state_q <= SEED;
    else if (adv)    state_q <= {state_q[LEN-2:0], fb};
  end
endmodule

// File: rtl/sdm_shaper.sv
// Combines the stage carries with difference terms into the signed offset.
module sdm_shaper
  import sdm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                adv,
  input  logic [STAGES-1:0]   carries,
  output off_t                offset
);
  logic c2_d1, c3_d1, c3_d2;
  int   acc;

  always_comb begin
    acc = int'(carries[0])
        + int'(carries[1]) - int'(c2_d1)
        + int'(carries[2]) - 2 * int'(c3_d1) + int'(c3_d2);
    offset = off_t'(acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_d1 <= 1'b0; c3_d1 <= 1'b0; c3_d2 <= 1'b0;
    end else if (clr) begin
      c2_d1 <= 1'b0; c3_d1 <= 1'b0; c3_d2 <= 1'b0;
    end else if (adv) begin
      c2_d1 <= carries[1];
      c3_d1 <= carries[2];
      c3_d2 <= c3_d1;
    end
  end
endmodule

// File: rtl/sdm_frac_interp.sv
// Fractional interpolator: three modulo-MOD stages, noise-shaping combiner,
// optional LSB dither, divide values out on a valid/ready stream.
module sdm_frac_interp
  import sdm_pkg::*;
#(
  parameter int INT_W = 10,
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [INT_W-1:0] cfg_int,
  input  logic [MOD_W-1:0] cfg_frac,
  input  logic [MOD_W-1:0] cfg_mod,
  input  logic             cfg_dither,
  output logic             cfg_err,
  output logic             div_valid,
  input  logic             div_ready,
  output logic [INT_W:0]   div_value
);
  localparam logic [MOD_W-1:0] MOD_FLOOR = MOD_W'(MIN_MOD);
  localparam logic [MOD_W-1:0] DITH_FLOOR = MOD_W'(DITHER_MIN_MOD);
  localparam int               EXT_W = INT_W - 3;

  logic [INT_W-1:0] n_q;
  logic [MOD_W-1:0] frac_q, mod_q;
  logic             dith_q, valid_q, err_q;
  logic             bad_cfg, adv, prbs_bit, dith_bit;
  logic [STAGES-1:0] carries;
  logic [MOD_W:0]    addend [STAGES];
  logic [MOD_W-1:0]  resid  [STAGES];
  logic [MOD_W-1:0]  last_resid_unused;
  off_t              offset;

  assign bad_cfg = (cfg_mod < MOD_FLOOR) || (cfg_frac >= cfg_mod) ||
                   (cfg_dither && (cfg_mod < DITH_FLOOR));
  assign adv      = valid_q & div_ready & ~cfg_load;
  assign dith_bit = dith_q & prbs_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= '0; frac_q <= '0; mod_q <= '0;
      dith_q <= 1'b0; valid_q <= 1'b0; err_q <= 1'b0;
    end else if (cfg_load) begin
      err_q   <= bad_cfg;
      valid_q <= ~bad_cfg;
      if (!bad_cfg) begin
        n_q    <= cfg_int;
        frac_q <= cfg_frac;
        mod_q  <= cfg_mod;
        dith_q <= cfg_dither;
      end
    end
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign addend[k] = {1'b0, frac_q} + {{MOD_W{1'b0}}, dith_bit};
    end else begin : g_next
      assign addend[k] = {1'b0, resid[k-1]};
    end
    sdm_mod_accum #(.W(MOD_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(cfg_load), .adv(adv),
      .modulus(mod_q), .addend(addend[k]),
      .carry(carries[k]), .resid(resid[k])
    );
  end

  assign last_resid_unused = resid[STAGES-1];

  sdm_prbs u_dith (
    .clk(clk), .rst_n(rst_n), .reseed(cfg_load), .adv(adv), .bit_o(prbs_bit)
  );

  sdm_shaper u_shape (
    .clk(clk), .rst_n(rst_n), .clr(cfg_load), .adv(adv),
    .carries(carries), .offset(offset)
  );

  assign div_value = {1'b0, n_q} + {{EXT_W{offset[3]}}, offset};
  assign div_valid = valid_q;
  assign cfg_err   = err_q;
endmodule

// File: rtl/sdm_frac_interp_chk.sv
module sdm_frac_interp_chk #(
  parameter int INT_W = 10,
  parameter int MOD_W = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_load,
  input logic [INT_W-1:0]     cfg_int,
  input logic [MOD_W-1:0]     cfg_frac,
  input logic [MOD_W-1:0]     cfg_mod,
  input logic                 cfg_dither,
  input logic                 cfg_err,
  input logic                 div_valid,
  input logic                 div_ready,
  input logic [INT_W:0]       div_value,
  input logic [INT_W-1:0]     n_q,
  input logic [sdm_pkg::PRBS_LEN-1:0] prbs_state
);
  logic load_legal;
  assign load_legal = (int'(cfg_mod) >= 2) && (cfg_frac < cfg_mod) &&
                      (!cfg_dither || int'(cfg_mod) >= 50);

  // R1
  a_r1_idle_in_reset: assert property (@(posedge clk)
    !rst_n |=> !div_valid && !cfg_err);

  // R2
  a_r2_load_starts_at_n: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load && load_legal && !cfg_dither |=>
      div_valid && !cfg_err && div_value == {1'b0, $past(cfg_int)});

  // R3
  a_r3_bad_load_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load && !load_legal |=> cfg_err && !div_valid);

  // R4
  a_r4_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
    div_valid |-> (int'(div_value) - int'(n_q) >= -3) &&
                  (int'(div_value) - int'(n_q) <= 4));

  // R7
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    div_valid && !div_ready && !cfg_load |=> div_valid && $stable(div_value));

  // R9
  a_r9_prbs_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    prbs_state != '0);
endmodule

bind sdm_frac_interp sdm_frac_interp_chk #(.INT_W(INT_W), .MOD_W(MOD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_int(cfg_int),
  .cfg_frac(cfg_frac), .cfg_mod(cfg_mod), .cfg_dither(cfg_dither),
  .cfg_err(cfg_err), .div_valid(div_valid), .div_ready(div_ready),
  .div_value(div_value), .n_q(n_q), .prbs_state(u_dith.state_q)
);

// File: tb/sim_sdm_frac_interp.sv
module sim_sdm_frac_interp;
  localparam int CLK_PERIOD = 10;
  localparam int INT_W = 10;
  localparam int MOD_W = 12;
  localparam int NV = 8;
  // mod, frac, n, repeat length, offset sum over one repeat
  localparam int VEC [NV][5] = '{
    '{7, 3, 100, 7, 3},
    '{10, 3, 200, 20, 6},
    '{9, 4, 50, 27, 12},
    '{12, 5, 300, 72, 30},
    '{25, 24, 17, 25, 24},
    '{2, 1, 10, 4, 2},
    '{60, 7, 900, 360, 42},
    '{13, 0, 33, 13, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [INT_W-1:0] cfg_int = '0;
  logic [MOD_W-1:0] cfg_frac = '0;
  logic [MOD_W-1:0] cfg_mod = '0;
  logic cfg_dither = 1'b0;
  logic cfg_err, div_valid;
  logic div_ready = 1'b1;
  logic [INT_W:0] div_value;

  int n_checks = 0;
  int n_fails = 0;
  int samp [1024];
  int refq [1024];
  bit done = 1'b0;

  sdm_frac_interp #(.INT_W(INT_W), .MOD_W(MOD_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_int(cfg_int),
    .cfg_frac(cfg_frac), .cfg_mod(cfg_mod), .cfg_dither(cfg_dither),
    .cfg_err(cfg_err), .div_valid(div_valid), .div_ready(div_ready),
    .div_value(div_value)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic do_load(input int n, input int frac, input int md, input bit dith);
    @(negedge clk);
    cfg_int = INT_W'(n); cfg_frac = MOD_W'(frac); cfg_mod = MOD_W'(md);
    cfg_dither = dith; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // record values [from, upto) with ready held high, one per cycle
  task automatic collect(input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      samp[i] = int'(div_value);
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: idle during and after reset
    check(!div_valid && !cfg_err, "R1 idle in reset", int'(div_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!div_valid && !cfg_err, "R1 idle after reset", int'(div_valid), 0);

    // vector table: dither off, R2 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      int md, fr, n, len, want_sum, mism, s, out_rng;
      md = VEC[v][0]; fr = VEC[v][1]; n = VEC[v][2];
      len = VEC[v][3]; want_sum = VEC[v][4];
      do_load(n, fr, md, 1'b0);
      check(div_valid && !cfg_err, "R2 load accepted", int'(cfg_err), 0);
      collect(0, 2 * len + 2);
      check(samp[0] == n, "R2 first value is N", samp[0], n);
      mism = 0; s = 0; out_rng = 0;
      for (int i = 2; i < len + 2; i++) begin
        if (samp[i] != samp[i + len]) mism++;
        s += samp[i] - n;
      end
      for (int i = 0; i < 2 * len + 2; i++)
        if (samp[i] - n < -3 || samp[i] - n > 4) out_rng++;
      check(mism == 0, "R6 repeat length", mism, 0);
      check(s == want_sum, "R5 offset sum over repeat", s, want_sum);
      check(out_rng == 0, "R4 offset range", out_rng, 0);
    end

    // R8: wrap at the largest modulus
    do_load(500, 4094, 4095, 1'b0);
    collect(0, 4);
    check(samp[0] == 500, "R8 step0", samp[0], 500);
    check(samp[1] == 503, "R8 step1", samp[1], 503);
    check(samp[2] == 500, "R8 step2", samp[2], 500);
    check(samp[3] == 501, "R8 step3", samp[3], 501);

    // R7 and R10: reference run, reload mid-stream, stall, resume
    do_load(100, 3, 7, 1'b0);
    collect(0, 12);
    for (int i = 0; i < 12; i++) refq[i] = samp[i];
    do_load(100, 3, 7, 1'b0);
    check(int'(div_value) == refq[0], "R10 reload restarts", int'(div_value), refq[0]);
    collect(0, 3);
    div_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(div_valid && int'(div_value) == refq[3], "R7 stall holds value",
            int'(div_value), refq[3]);
      @(negedge clk);
    end
    div_ready = 1'b1;
    collect(3, 12);
    begin
      int mism = 0;
      for (int i = 3; i < 12; i++) if (samp[i] != refq[i]) mism++;
      check(mism == 0, "R7 resume without skip", mism, 0);
    end

    // R3: illegal loads
    do_load(100, 7, 40, 1'b1);
    check(cfg_err && !div_valid, "R3 dither with MOD<50", int'(cfg_err), 1);
    do_load(100, 0, 1, 1'b0);
    check(cfg_err && !div_valid, "R3 MOD<2", int'(cfg_err), 1);
    do_load(100, 20, 20, 1'b0);
    check(cfg_err && !div_valid, "R3 FRAC>=MOD", int'(cfg_err), 1);

    // R9: dither boundary, reproducibility, effect
    do_load(100, 7, 50, 1'b1);
    check(div_valid && !cfg_err, "R2 dither at MOD=50 accepted", int'(cfg_err), 0);
    collect(0, 120);
    for (int i = 0; i < 120; i++) refq[i] = samp[i];
    do_load(100, 7, 50, 1'b1);
    collect(0, 120);
    begin
      int mism = 0, out_rng = 0;
      for (int i = 0; i < 120; i++) begin
        if (samp[i] != refq[i]) mism++;
        if (samp[i] - 100 < -3 || samp[i] - 100 > 4) out_rng++;
      end
      check(mism == 0, "R9 dither reproducible after load", mism, 0);
      check(out_rng == 0, "R4 dithered offset range", out_rng, 0);
    end
    do_load(100, 7, 50, 1'b0);
    collect(0, 120);
    begin
      int diffs = 0;
      for (int i = 0; i < 120; i++) if (samp[i] != refq[i]) diffs++;
      check(diffs > 0, "R9 dither changes sequence", diffs, 1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule